// File: doc/BRIEF.md
# SMBus Packet Error Code Unit

This block lives in the byte path of an SMBus host controller and owns the packet error code (PEC), a CRC-8 over every byte that crosses the wire in one transaction. The controller signals each transaction start with the transaction's PEC enable, plain-I2C flag and direction. It then shows the unit every byte it sends and every byte it receives. Sent bytes include address bytes with their R/W bit, command bytes, count bytes, data bytes and any repeated address after a repeated start.

On a write with the code enabled, the unit asks for one extra byte and presents the running code as that byte. The controller sends it after the last data byte, and no firmware step is involved. On a read with the code enabled, the target's final byte is taken as the code. The unit compares it with the locally computed value and raises a sticky error flag on a mismatch. That final byte is held back from the receive buffer. When PEC is disabled, or when the transaction runs in plain I2C mode, the unit stays silent. Bit-level bus signalling is handled elsewhere.

Top module: `smbus_pec_unit`

## Requirements
- R1: After reset, `pec_byte` is 0x00 and `pec_append` and `pec_err` are low.
- R2: A `start` pulse clears the code register to 0x00 and latches the transaction mode. The code is active when `pec_en` is 1 and `i2c_mode` is 0. `rd_dir` = 1 marks a read and 0 marks a write.
- R3: The code is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, taken MSB first with no final inversion. Each byte taken while the code is active updates it, and the new value shows on `pec_byte` in the cycle after the byte. For example, a single byte 0x01 gives 0x07, and the ASCII string "123456789" gives 0xF4.
- R4: On an active write, `pec_append` is high and `pec_byte` holds the code over all bytes sent so far. Once that code byte is itself sent through `tx_valid`, `pec_byte` reads 0x00.
- R5: On an active read, a received byte with `rx_last` high is compared with `pec_byte` as it stood before that byte. A mismatch sets `pec_err` in the next cycle, and a match leaves `pec_err` unchanged.
- R6: On an active read, the byte marked `rx_last` does not reach the buffer, so `buf_we` stays low for it. Every other received byte drives `buf_we` high in the same cycle, with `buf_data` equal to `rx_byte`.
- R7: `pec_err` stays set until an `err_clr` pulse. If a mismatch and `err_clr` arrive in the same cycle, the flag is set.
- R8: With PEC disabled or in plain I2C mode, `pec_byte` stays 0x00, `pec_append` stays low, no error is raised, and the final received byte is written to the buffer.
- R9: Bytes sent and received in one transaction, including the repeated address of a combined read, all feed a single running code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transaction start pulse |
| pec_en | input | 1 | PEC requested for this transaction (sampled on start) |
| i2c_mode | input | 1 | Plain I2C transaction (sampled on start) |
| rd_dir | input | 1 | 1 = read, 0 = write (sampled on start) |
| tx_valid | input | 1 | A byte is sent on the wire this cycle |
| tx_byte | input | 8 | Sent byte |
| rx_valid | input | 1 | A byte is received from the wire this cycle |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | Received byte is the final byte of the transaction |
| err_clr | input | 1 | Clears the error flag |
| pec_byte | output | 8 | Running code, the byte to append on writes |
| pec_append | output | 1 | Controller must append `pec_byte` after the data |
| pec_err | output | 1 | Sticky code mismatch flag |
| buf_we | output | 1 | Write strobe to the receive buffer |
| buf_data | output | 8 | Data to the receive buffer |

## Verification
The bench checks the published CRC-8 check values to catch a reflected or wrongly seeded polynomial. It sends the appended code back through the unit, where a wrong register gives a nonzero residue instead of 0x00. Combined reads carry a repeated address and a corrupted final byte. A design that left out sent bytes, compared after updating, or let the code byte into the buffer would then show a false error, a missed error or a stray `buf_we`. It also drives a mismatch in the same cycle as `err_clr`, and it runs I2C and PEC-disabled transactions, where a leaking design would append a code or flag an error.

// File: rtl/smbus_pec_unit.sv
module smbus_pec_unit #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 8'h07,
  parameter logic [W-1:0] INIT = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         pec_en,
  input  logic         i2c_mode,
  input  logic         rd_dir,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_byte,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_last,
  input  logic         err_clr,
  output logic [W-1:0] pec_byte,
  output logic         pec_append,
  output logic         pec_err,
  output logic         buf_we,
  output logic [W-1:0] buf_data
);

  logic [W-1:0] crc;
  logic         act, rd;
  logic         take_tx, take_rx, code_in, mismatch;

  function automatic logic [W-1:0] crc_step(input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] r;
    logic fb;
    r = c;
    for (int i = W - 1; i >= 0; i--) begin
      fb = r[W-1] ^ d[i];
      r  = {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  assign take_tx  = act & tx_valid & ~start;
  assign take_rx  = act & rx_valid & ~tx_valid & ~start;
  assign code_in  = act & rd & rx_valid & rx_last;
  assign mismatch = take_rx & rd & rx_last & (rx_byte != crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= INIT;
      act <= 1'b0;
      rd  <= 1'b0;
    end else if (start) begin
      crc <= INIT;
      act <= pec_en & ~i2c_mode;
      rd  <= rd_dir;
    end else if (take_tx) begin
      crc <= crc_step(crc, tx_byte);
    end else if (take_rx) begin
      crc <= crc_step(crc, rx_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pec_err <= 1'b0;
    else if (mismatch) pec_err <= 1'b1;
    else if (err_clr)  pec_err <= 1'b0;
  end

  assign pec_byte   = crc;
  assign pec_append = act & ~rd;
  assign buf_we     = rx_valid & ~code_in;
  assign buf_data   = rx_byte;

endmodule

// File: rtl/smbus_pec_unit_chk.sv
module smbus_pec_unit_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = 8'h00
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         err_clr,
  input logic         rx_valid,
  input logic         rx_last,
  input logic         act,
  input logic         rd,
  input logic [W-1:0] pec_byte,
  input logic         pec_err,
  input logic         buf_we
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pec_byte == INIT); // R2

  AST_CODE_NOT_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_last && act && rd) |-> !buf_we); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_err && !err_clr) |=> pec_err); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pec_err) |-> $past(rx_valid && rx_last && act && rd)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !start) |=> $stable(pec_byte)); // R8

endmodule

bind smbus_pec_unit smbus_pec_unit_chk #(.W(W), .INIT(INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .err_clr(err_clr),
  .rx_valid(rx_valid), .rx_last(rx_last), .act(act), .rd(rd),
  .pec_byte(pec_byte), .pec_err(pec_err), .buf_we(buf_we)
);

// File: tb/sim_smbus_pec_unit.sv
module sim_smbus_pec_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, pec_en = 0, i2c_mode = 0, rd_dir = 0;
  logic tx_valid = 0, rx_valid = 0, rx_last = 0, err_clr = 0;
  logic [7:0] tx_byte = 0, rx_byte = 0;
  logic [7:0] pec_byte, buf_data;
  logic pec_append, pec_err, buf_we;

  int checks = 0, errors = 0;
  logic [7:0] m_crc;
  logic m_act = 0, m_rd = 0, m_err = 0;

  always #2 clk = ~clk;

  smbus_pec_unit u0 (.*);

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic begin_txn(input bit en, input bit i2c, input bit rd);
    @(negedge clk);
    start = 1; pec_en = en; i2c_mode = i2c; rd_dir = rd;
    @(negedge clk);
    start = 0;
    m_crc = 8'h00; m_act = en & !i2c; m_rd = rd;
    chk(pec_byte == 8'h00, "R2", pec_byte, 0);
  endtask

  task automatic put_tx(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1; tx_byte = b;
    @(negedge clk);
    tx_valid = 0;
    if (m_act) m_crc = crc8(m_crc, b);
  endtask

  task automatic put_rx(input logic [7:0] b, input bit last, input bit clr);
    bit exp_we;
    @(negedge clk);
    rx_valid = 1; rx_byte = b; rx_last = last; err_clr = clr;
    exp_we = !(last && m_act && m_rd);
    #1;
    chk(buf_we == exp_we, m_act ? "R6" : "R8", buf_we, exp_we);
    if (exp_we) chk(buf_data == b, "R6", buf_data, b);
    @(negedge clk);
    rx_valid = 0; rx_last = 0; err_clr = 0;
    if (clr) m_err = 0;
    if (last && m_act && m_rd && b != m_crc) m_err = 1;
    if (m_act) m_crc = crc8(m_crc, b);
    chk(pec_err == m_err, "R5/R7", pec_err, m_err);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0; m_err = 0;
    chk(pec_err == 0, "R7", pec_err, 0);
  endtask

  task automatic do_write(input bit en, input bit i2c, input int n);
    begin_txn(en, i2c, 0);
    put_tx(8'h2C);
    for (int i = 0; i < n; i++) put_tx(8'($urandom));
    chk(pec_append == (en && !i2c), "R4", pec_append, en && !i2c);
    chk(pec_byte == m_crc, "R3", pec_byte, m_crc);
    if (en && !i2c) begin
      put_tx(pec_byte);
      chk(pec_byte == 8'h00, "R4", pec_byte, 0);
    end else chk(pec_byte == 8'h00, "R8", pec_byte, 0);
  endtask

  task automatic do_read(input bit en, input bit i2c, input int n, input bit bad, input bit clr);
    begin_txn(en, i2c, 1);
    chk(pec_append == 0, "R4", pec_append, 0);
    put_tx(8'hA6); put_tx(8'h11); put_tx(8'hA7);
    for (int i = 0; i < n; i++) put_rx(8'($urandom), 0, 0);
    chk(pec_byte == m_crc, "R9", pec_byte, m_crc);
    put_rx(bad ? m_crc ^ 8'h5A : m_crc, 1, clr);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk(pec_byte == 0, "R1", pec_byte, 0);
    chk(pec_append == 0, "R1", pec_append, 0);
    chk(pec_err == 0, "R1", pec_err, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    begin_txn(1, 0, 0);
    put_tx(8'h01);
    chk(pec_byte == 8'h07, "R3", pec_byte, 8'h07);
    begin_txn(1, 0, 0);
    for (int i = 0; i < 9; i++) put_tx(8'h31 + 8'(i));
    chk(pec_byte == 8'hF4, "R3", pec_byte, 8'hF4);

    do_write(1, 0, 32);
    do_read(1, 0, 5, 0, 0);
    do_read(1, 0, 5, 1, 0);
    do_read(1, 0, 3, 0, 0);
    chk(pec_err == 1, "R7", pec_err, 1);
    clear_err();
    do_read(1, 0, 2, 1, 1);
    chk(pec_err == 1, "R7", pec_err, 1);
    clear_err();
    do_read(0, 0, 4, 1, 0);
    do_read(1, 1, 4, 1, 0);
    chk(pec_byte == 0 && pec_err == 0, "R8", pec_byte, 0);
    do_write(1, 1, 6);

    for (int t = 0; t < 60; t++) begin
      bit en, i2c;
      int n;
      en = 1'($urandom); i2c = ($urandom % 4) == 0; n = 1 + ($urandom % 32);
      if ($urandom % 2) do_write(en, i2c, n);
      else do_read(en, i2c, n, 1'($urandom), 0);
      if (m_err && ($urandom % 2)) clear_err();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule